// File: doc/BRIEF.md
# Timer Event Collector with Trigger Timestamp Capture

This block gathers the event flags of a precision nanosecond timer into one sticky event register and drives a single interrupt line from it. Two asynchronous trigger pins are watched. When a pin shows the edge picked by its polarity bit, the block latches the running 64-bit time value into that pin's snapshot registers and raises the pin's event flag. Alarm-match and periodic-pulse strobes from neighbouring timer logic set their own flags directly.

Software reaches the block through a small word-addressed register bus. Every register can be read. The event register is acknowledged by writing ones to the flags that have been serviced. A mask register picks which flags may assert the interrupt. Each snapshot appears as an upper and a lower 32-bit word. Both halves are loaded on the same clock, so the pair stays consistent whichever half is read first, and the intended order is upper word first.

Register map (word addresses): 0 control, 1 events, 2 interrupt enables, 3 trigger-1 upper word, 4 trigger-1 lower word, 5 trigger-2 upper word, 6 trigger-2 lower word. Every other address reads as zero.

Top module: `tstamp_event_unit`

## Requirements
- R1: A synchronous active-high reset clears the control, event and enable registers, both snapshots and the interrupt output. Every register then reads as zero.
- R2: Control bit 8 sets the active edge for trigger 1 and control bit 9 sets it for trigger 2. A value of 0 selects the rising edge and 1 selects the falling edge. An edge of the other direction captures nothing and sets no flag. Only bits 8 and 9 of the control register are stored; all other control bits read as 0.
- R3: Each trigger pin passes through two synchronizer flops. A level change sampled at clock edge k is detected at edge k+2. At that edge the time input is loaded into the pin's snapshot, and event bit 24 (trigger 1) or bit 25 (trigger 2) is set. The upper 32 bits of the snapshot read at address 3 or 5, and the lower 32 bits at address 4 or 6.
- R4: Strobes set event flags on the clock edge where they are high: alarm 1 sets bit 16, alarm 2 sets bit 17, pulse 1 sets bit 7, pulse 2 sets bit 6 and pulse 3 sets bit 5. A flag stays set until it is acknowledged. No flag is set without its source.
- R5: A write to the event register clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If a flag is set and cleared on the same clock edge, it ends up set.
- R6: The interrupt-enable register uses the event bit positions. Only bits 25, 24, 17, 16, 7, 6 and 5 are stored; all other enable bits read as 0.
- R7: The interrupt output is a flop that holds the OR over all bits of (events AND enables) as they stood one clock earlier.
- R8: An edge on a trigger whose flag is still set reloads that trigger's snapshot with the new time, and the flag stays set.
- R9: Read data is registered. The value on the data output reflects the register at the address presented on the previous clock edge. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| time_ns | input | TIME_W | Current timer value in nanoseconds |
| trig_pin | input | NUM_TRIG | Asynchronous trigger pins; bit 0 is trigger 1 |
| alarm_hit | input | 2 | Alarm-match strobes; bit 0 is alarm 1 |
| pulse_hit | input | 3 | Periodic-pulse strobes; bit 0 is pulse 1 |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Word address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag that is set by mistake or left uncleared shows up in two places: in the event word read one clock after the address is presented, and on the interrupt line one clock after the flag changes. A reference model of the register state, compared on every clock, therefore reports it within two cycles. A synchronizer of the wrong depth or a wrong edge decode moves or drops the capture, so the snapshot words read back a different time than the model. A wrong reload rule likewise leaves an older time in the snapshot. The most likely bugs are a lost set-versus-acknowledge race and stray bits in the stored register fields. Directed cases cover both, checked against values worked out by hand.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int DATA_W    = 32;
  // event bit positions (also used by the enable register)
  localparam int EV_PULSE3 = 5;
  localparam int EV_PULSE2 = 6;
  localparam int EV_PULSE1 = 7;
  localparam int EV_ALARM1 = 16;
  localparam int EV_ALARM2 = 17;
  localparam int EV_TRIG_BASE = 24;
  // control bit of trigger 1 edge select; trigger 2 is the next bit
  localparam int POL_BASE  = 8;
  localparam logic [DATA_W-1:0] EV_VALID = 32'h0303_00E0;
  // word addresses
  localparam int A_CTRL  = 0;
  localparam int A_EVENT = 1;
  localparam int A_MASK  = 2;
  localparam int A_SNAP  = 3;  // trigger i upper at A_SNAP+2i, lower at A_SNAP+2i+1
  localparam int A_LAST  = 6;
endpackage

// File: rtl/tec_trig_edge.sv
module tec_trig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic hit_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;
  logic            cur;
  logic            prev;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign cur   = sh[STAGES-1];
  assign prev  = sh[STAGES];
  assign hit_o = fall_sel ? (prev & ~cur) : (cur & ~prev);

  // R2: with a steady edge select, two detections cannot follow back to back
  p_edge_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !(hit_o && $stable(fall_sel)));
endmodule

// File: rtl/tec_capture.sv
module tec_capture #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] snap_o
);
  always_ff @(posedge clk) begin
    if (rst)       snap_o <= '0;
    else if (take) snap_o <= time_i;
  end

  // R3 / R8: every detection reloads the snapshot, even if the flag is set
  p_snap_loads_r3: assert property (@(posedge clk) disable iff (rst)
    take |=> snap_o == $past(time_i));
  // R8: without a detection the snapshot holds
  p_snap_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(snap_o));
endmodule

// File: rtl/tec_event_bank.sv
module tec_event_bank #(
  parameter int                DW    = 32,
  parameter logic [DW-1:0]     VALID = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic          mask_wr,
  input  logic [DW-1:0] mask_wdata,
  output logic [DW-1:0] evt_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] evt_d;

  // acknowledge first, then set: a set on the same edge wins
  assign evt_d = ((evt_o & ~clr_i) | set_i) & VALID;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_o  <= '0;
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      evt_o <= evt_d;
      if (mask_wr) mask_o <= mask_wdata & VALID;
      irq_o <= |(evt_o & mask_o);
    end
  end

  // R5: set beats a same-cycle acknowledge
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    ((set_i & VALID) != '0) |=> ((evt_o & $past(set_i & VALID)) == $past(set_i & VALID)));
  // R5: an acknowledged flag with no set is gone next cycle
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_o & $past(clr_i & ~set_i)) == '0));
  // R4: no flag rises without a source
  p_no_phantom_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((evt_o & ~$past(evt_o) & ~$past(set_i)) == '0));
  // R7: interrupt needs a flag one cycle earlier
  p_irq_source_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(evt_o) != '0));
  // R7: all enables off silences the line
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_o) == '0) |-> !irq_o);
endmodule

// File: rtl/tstamp_event_unit.sv
module tstamp_event_unit
  import tec_pkg::*;
#(
  parameter int TIME_W    = 64,
  parameter int ADDR_W    = 4,
  parameter int NUM_TRIG  = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TIME_W-1:0]   time_ns,
  input  logic [NUM_TRIG-1:0] trig_pin,
  input  logic [1:0]          alarm_hit,
  input  logic [2:0]          pulse_hit,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq
);
  localparam int HI_W = TIME_W - DATA_W;

  logic [NUM_TRIG-1:0] pol_q;
  logic [NUM_TRIG-1:0] hit;
  logic [TIME_W-1:0]   snap [NUM_TRIG];
  logic [DATA_W-1:0]   set_v;
  logic [DATA_W-1:0]   clr_v;
  logic [DATA_W-1:0]   evt;
  logic [DATA_W-1:0]   msk;
  logic [DATA_W-1:0]   ctrl_rd;
  logic                wr_ctrl;
  logic                wr_evt;
  logic                wr_mask;
  logic [DATA_W-1:0]   rd_d;

  assign wr_ctrl = bus_wr && (int'(bus_addr) == A_CTRL);
  assign wr_evt  = bus_wr && (int'(bus_addr) == A_EVENT);
  assign wr_mask = bus_wr && (int'(bus_addr) == A_MASK);

  // edge-select bits are the only stored control state
  always_ff @(posedge clk) begin
    if (rst)          pol_q <= '0;
    else if (wr_ctrl) pol_q <= bus_wdata[POL_BASE +: NUM_TRIG];
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[POL_BASE +: NUM_TRIG] = pol_q;
  end

  // per-trigger synchronizer, edge detect and snapshot
  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    tec_trig_edge #(.STAGES(SYNC_STG)) u_edge (
      .clk      (clk),
      .rst      (rst),
      .pin      (trig_pin[i]),
      .fall_sel (pol_q[i]),
      .hit_o    (hit[i])
    );
    tec_capture #(.TIME_W(TIME_W)) u_cap (
      .clk    (clk),
      .rst    (rst),
      .take   (hit[i]),
      .time_i (time_ns),
      .snap_o (snap[i])
    );
  end

  always_comb begin
    set_v = '0;
    set_v[EV_TRIG_BASE +: NUM_TRIG] = hit;
    set_v[EV_ALARM1] = alarm_hit[0];
    set_v[EV_ALARM2] = alarm_hit[1];
    set_v[EV_PULSE1] = pulse_hit[0];
    set_v[EV_PULSE2] = pulse_hit[1];
    set_v[EV_PULSE3] = pulse_hit[2];
  end

  assign clr_v = wr_evt ? bus_wdata : '0;

  tec_event_bank #(.DW(DATA_W), .VALID(EV_VALID)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set_i      (set_v),
    .clr_i      (clr_v),
    .mask_wr    (wr_mask),
    .mask_wdata (bus_wdata),
    .evt_o      (evt),
    .mask_o     (msk),
    .irq_o      (irq)
  );

  // registered read mux
  always_comb begin
    rd_d = '0;
    case (int'(bus_addr))
      A_CTRL:  rd_d = ctrl_rd;
      A_EVENT: rd_d = evt;
      A_MASK:  rd_d = msk;
      default: begin
        for (int i = 0; i < NUM_TRIG; i++) begin
          if (int'(bus_addr) == A_SNAP + 2*i)
            rd_d = DATA_W'(snap[i][TIME_W-1 -: HI_W]);
          if (int'(bus_addr) == A_SNAP + 2*i + 1)
            rd_d = snap[i][DATA_W-1:0];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  // R9: unmapped addresses read zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (int'($past(bus_addr)) > A_SNAP + 2*NUM_TRIG - 1) |-> (bus_rdata == '0));
  // R2: stored control holds only the edge-select field
  p_ctrl_field_r2: assert property (@(posedge clk) disable iff (rst)
    (int'($past(bus_addr)) == A_CTRL) |-> ((bus_rdata & ~(32'h3 << POL_BASE)) == '0));
endmodule

// File: tb/tstamp_event_unit_test.sv
module tstamp_event_unit_test;
  localparam int TW = 64;
  localparam int AW = 4;
  localparam logic [31:0] VALIDM = 32'h0303_00E0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] time_ns = 64'h0000_0001_FFFF_FF00;
  logic [1:0]    trig_pin = '0;
  logic [1:0]    alarm_hit = '0;
  logic [2:0]    pulse_hit = '0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  tstamp_event_unit uut (
    .clk(clk), .rst(rst), .time_ns(time_ns), .trig_pin(trig_pin),
    .alarm_hit(alarm_hit), .pulse_hit(pulse_hit), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_ctrl, m_evt, m_mask, exp_rdata;
  logic [63:0] m_cap0, m_cap1;
  logic        exp_irq;
  int          last_addr;
  bit          hq0[$];
  bit          hq1[$];

  function automatic logic [31:0] m_read(int a);
    case (a)
      0: return m_ctrl;
      1: return m_evt;
      2: return m_mask;
      3: return m_cap0[63:32];
      4: return m_cap0[31:0];
      5: return m_cap1[63:32];
      6: return m_cap1[31:0];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] setb, clrb;
    bit h0, h1;
    if (rst) begin
      m_ctrl = 0; m_evt = 0; m_mask = 0; m_cap0 = 0; m_cap1 = 0;
      exp_irq = 0; exp_rdata = 0; last_addr = 0;
      hq0 = '{0, 0, 0}; hq1 = '{0, 0, 0};
    end else begin
      exp_rdata = m_read(int'(bus_addr));
      last_addr = int'(bus_addr);
      exp_irq   = (m_evt & m_mask) != 0;
      setb = 0; clrb = 0;
      // a level sampled two edges ago against the one before it
      h0 = m_ctrl[8] ? (hq0[2] && !hq0[1]) : (hq0[1] && !hq0[2]);
      h1 = m_ctrl[9] ? (hq1[2] && !hq1[1]) : (hq1[1] && !hq1[2]);
      if (h0) begin m_cap0 = time_ns; setb[24] = 1; end
      if (h1) begin m_cap1 = time_ns; setb[25] = 1; end
      hq0.push_front(trig_pin[0]); void'(hq0.pop_back());
      hq1.push_front(trig_pin[1]); void'(hq1.pop_back());
      if (alarm_hit[0]) setb[16] = 1;
      if (alarm_hit[1]) setb[17] = 1;
      if (pulse_hit[0]) setb[7] = 1;
      if (pulse_hit[1]) setb[6] = 1;
      if (pulse_hit[2]) setb[5] = 1;
      if (bus_wr) begin
        if (bus_addr == 0) m_ctrl = bus_wdata & 32'h0000_0300;
        if (bus_addr == 1) clrb = bus_wdata;
        if (bus_addr == 2) m_mask = bus_wdata & VALIDM;
      end
      m_evt = ((m_evt & ~clrb) | setb) & VALIDM;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (!rst && !done) begin
      string tg;
      nvec++;
      case (last_addr)
        0: tg = "R2"; 1: tg = "R5"; 2: tg = "R6";
        3, 4, 5, 6: tg = "R3";
        default: tg = "R9";
      endcase
      if (bus_rdata !== exp_rdata) begin
        nfail++;
        $display("FAIL %s read addr %0d: actual %h expected %h", tg, last_addr, bus_rdata, exp_rdata);
      end
      if (irq !== exp_irq) begin
        nfail++;
        $display("FAIL R7 irq: actual %b expected %b", irq, exp_irq);
      end
    end
  end

  always @(negedge clk) time_ns <= time_ns + 64'd8;

  // ---------------- directed stimulus ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk); bus_addr = AW'(a);
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    idle(3);
    @(negedge clk) rst = 0;
    // R1: reset state
    for (int a = 0; a <= 6; a++) begin
      rd(a, v); chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 irq after reset", 32'(irq), 32'h0);
    // R9: unmapped read
    rd(9, v); chk("R9 unmapped", v, 32'h0);
    // R6 / R2: stored fields only
    wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R6 enable field", v, 32'h0303_00E0);
    wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 control field", v, 32'h0000_0300);
    wr(0, 32'h0);
    // R3: rising edge on trigger 1
    @(negedge clk) trig_pin[0] = 1;
    idle(5);
    rd(1, v); chk("R3 trig1 flag", v, 32'h0100_0000);
    rd(3, v); chk("R3 trig1 upper", v, m_cap0[63:32]);
    rd(4, v); chk("R3 trig1 lower", v, m_cap0[31:0]);
    chk("R7 irq with enabled flag", 32'(irq), 32'h1);
    // R5: acknowledge, then R2: falling edge ignored on rising select
    wr(1, 32'h0100_0000); rd(1, v); chk("R5 ack trig1", v, 32'h0);
    @(negedge clk) trig_pin[0] = 0;
    idle(5);
    rd(1, v); chk("R2 wrong edge no flag", v, 32'h0);
    // R2: falling select on trigger 2
    wr(0, 32'h0000_0200);
    @(negedge clk) trig_pin[1] = 1;
    idle(5);
    rd(1, v); chk("R2 rising ignored on falling select", v, 32'h0);
    @(negedge clk) trig_pin[1] = 0;
    idle(5);
    rd(1, v); chk("R2 falling captured trig2", v, 32'h0200_0000);
    rd(5, v); chk("R3 trig2 upper", v, m_cap1[63:32]);
    rd(6, v); chk("R3 trig2 lower", v, m_cap1[31:0]);
    // R8: second falling edge while flag set reloads snapshot
    begin
      logic [31:0] old_lo;
      old_lo = m_cap1[31:0];
      @(negedge clk) trig_pin[1] = 1;
      idle(3);
      @(negedge clk) trig_pin[1] = 0;
      idle(5);
      rd(6, v); chk("R8 reload lower", v, m_cap1[31:0]);
      chk("R8 snapshot moved", 32'(v != old_lo), 32'h1);
      rd(1, v); chk("R8 flag kept", v, 32'h0200_0000);
    end
    wr(1, 32'hFFFF_FFFF);
    // R4: strobes
    @(negedge clk) begin alarm_hit = 2'b11; pulse_hit = 3'b111; end
    @(negedge clk) begin alarm_hit = 0; pulse_hit = 0; end
    idle(2);
    rd(1, v); chk("R4 strobe flags", v, 32'h0003_00E0);
    // R5: partial acknowledge and zero write
    wr(1, 32'h0001_0000); rd(1, v); chk("R5 partial ack", v, 32'h0002_00E0);
    wr(1, 32'h0);         rd(1, v); chk("R5 zero write", v, 32'h0002_00E0);
    wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R5 ack all", v, 32'h0);
    // R5: set wins on same edge
    @(negedge clk) begin pulse_hit = 3'b001; bus_wr = 1; bus_addr = 1; bus_wdata = 32'h80; end
    @(negedge clk) begin pulse_hit = 0; bus_wr = 0; bus_wdata = 0; end
    rd(1, v); chk("R5 set beats ack", v, 32'h0000_0080);
    chk("R7 irq high", 32'(irq), 32'h1);
    // R7: disable all enables
    wr(2, 32'h0); idle(2);
    chk("R7 irq masked", 32'(irq), 32'h0);
    idle(4);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule